// File: doc/BRIEF.md
# USB Device Transaction Sequencer

This block is the transaction layer of a USB device endpoint engine. It sits between a packet layer and the application. The packet layer reports each received packet with an activity level, an end strobe, a 4-bit PID, a PID-present flag and an error flag. It transmits whatever the sequencer asks for through a send request and a completion strobe. The sequencer recognises token packets and tells the application which kind of transaction is running. It samples the application's reply choice inside a fixed window and waits the required inter-packet gap. It then issues data or a handshake, waits for the host's handshake where the protocol needs one, and reports each transaction with a one-cycle success or failure pulse.

Full-speed and high-speed operation use separate gap and timeout constants, chosen by the `hs_mode` input when `HS_EN` is set. Gaps and timeouts are counted from receive activity, never from line states. The sequencer keeps one data-toggle bit for each direction. It supports PING with the NYET handshake, and it ignores the echo of its own transmission while it waits for an acknowledge. CRC, line coding, descriptors and control requests are handled elsewhere.

Top module: `usbx_xact_seq`

## Requirements
- R1: A received packet that ends with `pkt_rx_fin`, `pkt_rx_pid_vld` high and `pkt_rx_err` low, while the sequencer is idle and carrying a token PID, starts a transaction. The token PIDs are OUT=4'h1, IN=4'h9, SETUP=4'hD and PING=4'h4. Exactly one of `app_in`, `app_out`, `app_setup`, `app_ping` goes high, and it stays high until the outcome pulse, when it is low.
- R2: The application inputs `app_send`, `app_nak`, `app_stall` and `app_nyet` are sampled once, at the second rising edge after the edge that registers the end of the token (IN/PING) or data packet (OUT/SETUP). Later changes have no effect. Priority is STALL over NAK over data or ACK.
- R3: `pkt_tx_send` rises exactly FS_IPD (default 14) cycles after the edge that registers the end of the received packet. With `HS_EN` set and `hs_mode` high, it rises HS_IPD (default 8) cycles after. `pkt_tx_send` then stays high until `pkt_tx_done`.
- R4: For IN, `app_send` selects a data packet whose PID is DATA0=4'h3 or DATA1=4'hB, following the IN toggle. Otherwise a NAK=4'hA or STALL=4'hE handshake is sent and the transaction ends with `xact_fail` when `pkt_tx_done` is seen.
- R5: After IN data, a clean ACK=4'h2 from the host gives `xact_ok` and flips the IN toggle. If the line stays quiet for FS_TMO (default 80) or HS_TMO (default 40) cycles after `pkt_tx_done`, the result is `xact_fail` and the toggle is kept.
- R6: A received packet that was already active while the sequencer transmitted data is the echo of that transmission. Its end is ignored while the sequencer waits for the host's ACK.
- R7: While waiting for an ACK or for a data packet, a packet that ends without a PID, with an error, or with the wrong PID ends the transaction with `xact_fail`, and no handshake is sent.
- R8: OUT data whose PID matches the expected OUT toggle is answered by the decision and, when acknowledged, gives `xact_ok` and flips the expectation. Data with the other PID is a repeat. It is answered with ACK regardless of `app_nak`/`app_stall`, gives `xact_fail`, and leaves the expectation unchanged.
- R9: A SETUP token forces the OUT expectation to DATA0. SETUP data is always acknowledged, ignoring `app_nak` and `app_stall`.
- R10: In high speed, fresh OUT data with `app_nyet` set is answered with NYET=4'h6 instead of ACK and counts as success. In full speed `app_nyet` has no effect.
- R11: In high speed, PING raises `app_ping`, uses the IN timing, and answers with ACK (`xact_ok`), NAK or STALL (`xact_fail`) with no data phase. In full speed a PING token is ignored.
- R12: A token whose end is registered in the cycle directly after an outcome pulse is accepted.
- R13: After reset all outputs are low and both toggles select DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | Attached at high speed |
| pkt_rx_act | input | 1 | Packet layer is receiving |
| pkt_rx_fin | input | 1 | One-cycle strobe: received packet ended |
| pkt_rx_pid_vld | input | 1 | The ended packet carried a PID |
| pkt_rx_err | input | 1 | The ended packet had an error |
| pkt_rx_pid | input | 4 | PID of the ended packet |
| pkt_tx_send | output | 1 | Request to transmit a packet |
| pkt_tx_pid | output | 4 | PID of the packet to transmit |
| pkt_tx_done | input | 1 | One-cycle strobe: transmission finished |
| app_in | output | 1 | IN transaction running |
| app_out | output | 1 | OUT transaction running |
| app_setup | output | 1 | SETUP transaction running |
| app_ping | output | 1 | PING transaction running |
| app_send | input | 1 | Application has IN data to send |
| app_nak | input | 1 | Application refuses (NAK) |
| app_stall | input | 1 | Endpoint halted (STALL) |
| app_nyet | input | 1 | Accept OUT data but answer NYET |
| xact_ok | output | 1 | One-cycle pulse: transaction succeeded |
| xact_fail | output | 1 | One-cycle pulse: transaction failed |

## Verification
A wrong toggle bit shows up at the next transaction in that direction. It appears as the wrong data PID on `pkt_tx_pid`, or as a repeat treated as fresh, which makes `xact_ok` appear where `xact_fail` belongs. A mis-counted gap timer moves the rise of `pkt_tx_send` away from its fixed distance after the received packet, which is visible within one transaction. A sequencer stuck in a wait state keeps an indication high and produces no outcome pulse, and the next token is then not accepted.

// File: rtl/usbx_pkg.sv
package usbx_pkg;
  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_IN    = 4'h9;
  localparam logic [3:0] PID_SETUP = 4'hD;
  localparam logic [3:0] PID_PING  = 4'h4;
  localparam logic [3:0] PID_DATA0 = 4'h3;
  localparam logic [3:0] PID_DATA1 = 4'hB;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_STALL = 4'hE;
  localparam logic [3:0] PID_NYET  = 4'h6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_RXDATA, ST_TXDATA, ST_TXHS, ST_WACK
  } seq_state_e;

  typedef enum logic [1:0] {
    XK_IN, XK_OUT, XK_SETUP, XK_PING
  } xact_kind_e;

  // what to transmit after the gap and whether it completes the transaction well
  typedef struct packed {
    logic       send_data;
    logic [3:0] pid;
    logic       good;
  } reply_plan_t;
endpackage

// File: rtl/usbx_gap_timer.sv
module usbx_gap_timer #(
  parameter int FS_IPD = 14,
  parameter int HS_IPD = 8,
  parameter int FS_TMO = 80,
  parameter int HS_TMO = 40,
  parameter int DEC_AT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_sel,
  input  logic clr,
  input  logic run,
  output logic dec_hit,
  output logic ipd_hit,
  output logic tmo_hit
);
  localparam int MAX_IPD = (FS_IPD > HS_IPD) ? FS_IPD : HS_IPD;
  localparam int MAX_TMO = (FS_TMO > HS_TMO) ? FS_TMO : HS_TMO;
  localparam int MAXV    = (MAX_IPD > MAX_TMO) ? MAX_IPD : MAX_TMO;
  localparam int CW      = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q, cnt_d, ipd_lim, tmo_lim;
  logic          cnt_en;

  assign ipd_lim = hs_sel ? CW'(HS_IPD - 1) : CW'(FS_IPD - 1);
  assign tmo_lim = hs_sel ? CW'(HS_TMO - 1) : CW'(FS_TMO - 1);

  always_comb begin
    cnt_en = clr || (run && (cnt_q != {CW{1'b1}}));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign dec_hit = run && !clr && (cnt_q == CW'(DEC_AT));
  assign ipd_hit = run && !clr && (cnt_q == ipd_lim);
  assign tmo_hit = run && !clr && (cnt_q == tmo_lim);
endmodule

// File: rtl/usbx_toggle_track.sv
module usbx_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_clr,
  input  logic out_flip,
  input  logic in_flip,
  output logic in_tog,
  output logic out_exp
);
  logic in_en, out_en, in_d, out_d;

  always_comb begin
    in_en  = in_flip;
    in_d   = ~in_tog;
    out_en = setup_clr || out_flip;
    out_d  = setup_clr ? 1'b0 : ~out_exp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_tog  <= 1'b0;
      out_exp <= 1'b0;
    end else begin
      if (in_en)  in_tog  <= in_d;
      if (out_en) out_exp <= out_d;
    end
  end
endmodule

// File: rtl/usbx_reply_decide.sv
module usbx_reply_decide
  import usbx_pkg::*;
(
  input  xact_kind_e  kind,
  input  logic        hs_act,
  input  logic        in_tog,
  input  logic        out_exp,
  input  logic [3:0]  data_pid,
  input  logic        app_send,
  input  logic        app_nak,
  input  logic        app_stall,
  input  logic        app_nyet,
  output reply_plan_t plan
);
  logic fresh;

  assign fresh = (data_pid == (out_exp ? PID_DATA1 : PID_DATA0));

  always_comb begin
    plan = '{send_data: 1'b0, pid: PID_NAK, good: 1'b0};
    unique case (kind)
      XK_IN: begin
        if (app_stall)     plan = '{send_data: 1'b0, pid: PID_STALL, good: 1'b0};
        else if (app_send) plan = '{send_data: 1'b1, pid: (in_tog ? PID_DATA1 : PID_DATA0), good: 1'b0};
        else               plan = '{send_data: 1'b0, pid: PID_NAK,   good: 1'b0};
      end
      XK_PING: begin
        if (app_stall)     plan = '{send_data: 1'b0, pid: PID_STALL, good: 1'b0};
        else if (app_nak)  plan = '{send_data: 1'b0, pid: PID_NAK,   good: 1'b0};
        else               plan = '{send_data: 1'b0, pid: PID_ACK,   good: 1'b1};
      end
      XK_SETUP: begin
        plan = '{send_data: 1'b0, pid: PID_ACK, good: fresh};
      end
      XK_OUT: begin
        if (!fresh)                   plan = '{send_data: 1'b0, pid: PID_ACK,   good: 1'b0};
        else if (app_stall)           plan = '{send_data: 1'b0, pid: PID_STALL, good: 1'b0};
        else if (app_nak)             plan = '{send_data: 1'b0, pid: PID_NAK,   good: 1'b0};
        else if (app_nyet && hs_act)  plan = '{send_data: 1'b0, pid: PID_NYET,  good: 1'b1};
        else                          plan = '{send_data: 1'b0, pid: PID_ACK,   good: 1'b1};
      end
      default: plan = '{send_data: 1'b0, pid: PID_NAK, good: 1'b0};
    endcase
  end
endmodule

// File: rtl/usbx_xact_seq.sv
module usbx_xact_seq
  import usbx_pkg::*;
#(
  parameter int FS_IPD = 14,
  parameter int HS_IPD = 8,
  parameter int FS_TMO = 80,
  parameter int HS_TMO = 40,
  parameter int DEC_AT = 1,
  parameter int HS_EN  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_mode,
  input  logic       pkt_rx_act,
  input  logic       pkt_rx_fin,
  input  logic       pkt_rx_pid_vld,
  input  logic       pkt_rx_err,
  input  logic [3:0] pkt_rx_pid,
  output logic       pkt_tx_send,
  output logic [3:0] pkt_tx_pid,
  input  logic       pkt_tx_done,
  output logic       app_in,
  output logic       app_out,
  output logic       app_setup,
  output logic       app_ping,
  input  logic       app_send,
  input  logic       app_nak,
  input  logic       app_stall,
  input  logic       app_nyet,
  output logic       xact_ok,
  output logic       xact_fail
);
  seq_state_e  state_q, state_d;
  xact_kind_e  kind_q, kind_d;
  reply_plan_t plan_q, plan_nx;
  logic [3:0]  dpid_q;
  logic        echo_q, echo_d, ok_q, ok_d, fail_q, fail_d;
  logic        plan_en, dpid_en;
  logic        tm_clr, tm_run, dec_hit, ipd_hit, tmo_hit;
  logic        setup_clr, out_flip, in_flip, in_tog, out_exp;
  logic        hs_act, rx_good, rx_is_data;

  generate
    if (HS_EN != 0) begin : g_hs_on
      assign hs_act = hs_mode;
    end else begin : g_hs_off
      assign hs_act = 1'b0;
    end
  endgenerate

  assign rx_good    = pkt_rx_fin && pkt_rx_pid_vld && !pkt_rx_err;
  assign rx_is_data = (pkt_rx_pid == PID_DATA0) || (pkt_rx_pid == PID_DATA1);

  usbx_gap_timer #(
    .FS_IPD(FS_IPD), .HS_IPD(HS_IPD), .FS_TMO(FS_TMO), .HS_TMO(HS_TMO), .DEC_AT(DEC_AT)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .hs_sel(hs_act), .clr(tm_clr), .run(tm_run),
    .dec_hit(dec_hit), .ipd_hit(ipd_hit), .tmo_hit(tmo_hit)
  );

  usbx_toggle_track i_toggle (
    .clk(clk), .rst_n(rst_n), .setup_clr(setup_clr), .out_flip(out_flip),
    .in_flip(in_flip), .in_tog(in_tog), .out_exp(out_exp)
  );

  usbx_reply_decide i_decide (
    .kind(kind_q), .hs_act(hs_act), .in_tog(in_tog), .out_exp(out_exp),
    .data_pid(dpid_q), .app_send(app_send), .app_nak(app_nak),
    .app_stall(app_stall), .app_nyet(app_nyet), .plan(plan_nx)
  );

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    echo_d    = echo_q;
    ok_d      = 1'b0;
    fail_d    = 1'b0;
    plan_en   = 1'b0;
    dpid_en   = 1'b0;
    tm_clr    = 1'b0;
    tm_run    = 1'b0;
    setup_clr = 1'b0;
    out_flip  = 1'b0;
    in_flip   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_good) begin
          if (pkt_rx_pid == PID_IN) begin
            kind_d = XK_IN;  state_d = ST_GAP;    tm_clr = 1'b1;
          end else if (pkt_rx_pid == PID_OUT) begin
            kind_d = XK_OUT; state_d = ST_RXDATA; tm_clr = 1'b1;
          end else if (pkt_rx_pid == PID_SETUP) begin
            kind_d = XK_SETUP; state_d = ST_RXDATA; tm_clr = 1'b1; setup_clr = 1'b1;
          end else if ((pkt_rx_pid == PID_PING) && hs_act) begin
            kind_d = XK_PING; state_d = ST_GAP;   tm_clr = 1'b1;
          end
        end
      end
      ST_GAP: begin
        tm_run = 1'b1;
        echo_d = 1'b0;
        if (dec_hit) plan_en = 1'b1;
        if (ipd_hit) state_d = plan_q.send_data ? ST_TXDATA : ST_TXHS;
      end
      ST_RXDATA: begin
        tm_run = !pkt_rx_act;
        tm_clr = pkt_rx_act;
        if (pkt_rx_fin) begin
          if (rx_good && rx_is_data) begin
            dpid_en = 1'b1; state_d = ST_GAP; tm_clr = 1'b1;
          end else begin
            state_d = ST_IDLE; fail_d = 1'b1;
          end
        end else if (tmo_hit) begin
          state_d = ST_IDLE; fail_d = 1'b1;
        end
      end
      ST_TXDATA: begin
        if (pkt_rx_act) echo_d = 1'b1;
        if (pkt_tx_done) begin
          state_d = ST_WACK; tm_clr = 1'b1;
        end
      end
      ST_WACK: begin
        tm_run = !pkt_rx_act;
        tm_clr = pkt_rx_act;
        if (pkt_rx_fin) begin
          if (echo_q) begin
            echo_d = 1'b0; tm_clr = 1'b1;
          end else if (rx_good && (pkt_rx_pid == PID_ACK)) begin
            state_d = ST_IDLE; ok_d = 1'b1; in_flip = 1'b1;
          end else begin
            state_d = ST_IDLE; fail_d = 1'b1;
          end
        end else if (tmo_hit) begin
          state_d = ST_IDLE; fail_d = 1'b1;
        end
      end
      ST_TXHS: begin
        if (pkt_tx_done) begin
          state_d = ST_IDLE;
          if (plan_q.good) begin
            ok_d = 1'b1;
            if ((kind_q == XK_OUT) || (kind_q == XK_SETUP)) out_flip = 1'b1;
          end else begin
            fail_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= XK_IN;
      plan_q  <= '0;
      dpid_q  <= '0;
      echo_q  <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      echo_q  <= echo_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
      if (plan_en) plan_q <= plan_nx;
      if (dpid_en) dpid_q <= pkt_rx_pid;
    end
  end

  always_comb begin
    pkt_tx_send = (state_q == ST_TXDATA) || (state_q == ST_TXHS);
    pkt_tx_pid  = pkt_tx_send ? plan_q.pid : 4'h0;
    app_in      = (state_q != ST_IDLE) && (kind_q == XK_IN);
    app_out     = (state_q != ST_IDLE) && (kind_q == XK_OUT);
    app_setup   = (state_q != ST_IDLE) && (kind_q == XK_SETUP);
    app_ping    = (state_q != ST_IDLE) && (kind_q == XK_PING);
    xact_ok     = ok_q;
    xact_fail   = fail_q;
  end
endmodule

// File: rtl/usbx_xact_seq_chk.sv
module usbx_xact_seq_chk #(
  parameter int FS_IPD = 14,
  parameter int HS_IPD = 8,
  parameter int HS_EN  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic hs_mode,
  input logic pkt_rx_fin,
  input logic pkt_tx_send,
  input logic pkt_tx_done,
  input logic app_in,
  input logic app_out,
  input logic app_setup,
  input logic app_ping,
  input logic xact_ok,
  input logic xact_fail
);
  logic [7:0] since_fin;
  logic [7:0] exp_gap;
  logic       since_en;

  assign exp_gap  = ((HS_EN != 0) && hs_mode) ? 8'(HS_IPD) : 8'(FS_IPD);
  assign since_en = pkt_rx_fin || (since_fin != 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_fin <= 8'hFF;
    else if (since_en) since_fin <= pkt_rx_fin ? 8'd0 : since_fin + 8'd1;
  end

  // R1
  ind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({app_in, app_out, app_setup, app_ping}));

  // R1
  ind_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_ok || xact_fail) |-> !(app_in || app_out || app_setup || app_ping));

  // R3
  reply_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_tx_send) |-> (since_fin == exp_gap));

  // R3
  send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_tx_send && !pkt_tx_done) |=> pkt_tx_send);

  // R5
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xact_ok && xact_fail));

  // R5
  ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xact_ok |=> !xact_ok);
endmodule

bind usbx_xact_seq usbx_xact_seq_chk #(
  .FS_IPD(FS_IPD), .HS_IPD(HS_IPD), .HS_EN(HS_EN)
) i_chk (
  .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .pkt_rx_fin(pkt_rx_fin),
  .pkt_tx_send(pkt_tx_send), .pkt_tx_done(pkt_tx_done), .app_in(app_in),
  .app_out(app_out), .app_setup(app_setup), .app_ping(app_ping),
  .xact_ok(xact_ok), .xact_fail(xact_fail)
);

// File: tb/test_usbx_xact_seq.sv
module test_usbx_xact_seq;
  import usbx_pkg::*;
  localparam int FS_IPD = 14;
  localparam int HS_IPD = 8;
  localparam int FS_TMO = 80;
  localparam int HS_TMO = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, hs_mode, rx_act, rx_fin, rx_vld, rx_err, tx_done;
  logic [3:0] rx_pid, tx_pid;
  logic tx_send, a_in, a_out, a_setup, a_ping, a_send, a_nak, a_stall, a_nyet, x_ok, x_fail;

  int  checks = 0;
  int  fails = 0;
  int  cyc = 0;
  bit  in_tog_m = 1'b0;
  bit  out_exp_m = 1'b0;

  usbx_xact_seq #(.FS_IPD(FS_IPD), .HS_IPD(HS_IPD), .FS_TMO(FS_TMO), .HS_TMO(HS_TMO))
  i_usbx_xact_seq (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .pkt_rx_act(rx_act), .pkt_rx_fin(rx_fin),
    .pkt_rx_pid_vld(rx_vld), .pkt_rx_err(rx_err), .pkt_rx_pid(rx_pid), .pkt_tx_send(tx_send),
    .pkt_tx_pid(tx_pid), .pkt_tx_done(tx_done), .app_in(a_in), .app_out(a_out),
    .app_setup(a_setup), .app_ping(a_ping), .app_send(a_send), .app_nak(a_nak),
    .app_stall(a_stall), .app_nyet(a_nyet), .xact_ok(x_ok), .xact_fail(x_fail)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] dpid(input bit t);
    return t ? PID_DATA1 : PID_DATA0;
  endfunction

  // received packet: len cycles of activity, then the end strobe
  task automatic pkt(input logic [3:0] pid, input bit vld, input bit err, input int len);
    for (int i = 0; i < len; i++) begin
      rx_act = 1'b1;
      @(negedge clk);
    end
    rx_act = 1'b0; rx_fin = 1'b1; rx_pid = pid; rx_vld = vld; rx_err = err;
    @(negedge clk);
    rx_fin = 1'b0; rx_vld = 1'b0; rx_err = 1'b0; rx_pid = 4'h0;
  endtask

  // decision given inside the window, scrambled after it; returns cycles to send
  task automatic gap(input bit snd, input bit nak, input bit stl, input bit nyt,
                     input bit s_snd, input bit s_nak, input bit s_stl, output int k);
    k = 0;
    while (!tx_send && k < 300) begin
      @(negedge clk);
      k++;
      if (k == 1) begin a_send = snd; a_nak = nak; a_stall = stl; a_nyet = nyt; end
      if (k == 2) begin a_send = s_snd; a_nak = s_nak; a_stall = s_stl; a_nyet = ~nyt; end
    end
    a_send = 1'b0; a_nak = 1'b0; a_stall = 1'b0; a_nyet = 1'b0;
  endtask

  task automatic send_out(input bit echo, output logic [3:0] pid);
    pid = tx_pid;
    if (echo) rx_act = 1'b1;
    repeat (3) @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13", "outputs after reset", {tx_send, a_in, a_out, a_setup, a_ping, x_ok, x_fail}, 0);
  endtask

  task automatic t_in_ack();
    int k; logic [3:0] p;
    pkt(PID_IN, 1, 0, 3);
    chk("R1", "indications after IN", {a_in, a_out, a_setup, a_ping}, 4'b1000);
    gap(1, 0, 0, 0, 0, 0, 0, k);
    chk("R3", "FS gap", k, FS_IPD);
    send_out(0, p);
    chk("R4", "IN data pid", p, dpid(in_tog_m));
    pkt(PID_ACK, 1, 0, 2);
    chk("R5", "ok after host ACK", x_ok, 1);
    chk("R1", "indication dropped", a_in, 0);
    in_tog_m = ~in_tog_m;
  endtask

  task automatic t_in_timeout();
    int k; logic [3:0] p;
    pkt(PID_IN, 1, 0, 3);
    gap(1, 0, 0, 0, 0, 0, 0, k);
    send_out(0, p);
    chk("R5", "toggled data pid", p, dpid(in_tog_m));
    k = 0;
    while (!x_fail && k < 500) begin @(negedge clk); k++; end
    chk("R5", "FS timeout cycles", k, FS_TMO);
  endtask

  task automatic t_in_echo();
    int k; logic [3:0] p;
    pkt(PID_IN, 1, 0, 3);
    gap(1, 0, 0, 0, 0, 0, 0, k);
    send_out(1, p);
    pkt(p, 1, 0, 0);
    chk("R6", "echo end ignored", {x_ok, x_fail}, 0);
    pkt(PID_ACK, 1, 0, 2);
    chk("R6", "ACK after echo", x_ok, 1);
    in_tog_m = ~in_tog_m;
  endtask

  task automatic t_in_empty();
    int k; logic [3:0] p;
    pkt(PID_IN, 1, 0, 3);
    gap(1, 0, 0, 0, 0, 0, 0, k);
    send_out(0, p);
    pkt(4'h0, 0, 0, 2);
    chk("R7", "empty reply fails", x_fail, 1);
  endtask

  task automatic t_in_refuse();
    int k; logic [3:0] p;
    pkt(PID_IN, 1, 0, 3);
    gap(0, 1, 0, 0, 1, 0, 0, k);
    send_out(0, p);
    chk("R2", "late send ignored, NAK sent", p, PID_NAK);
    chk("R4", "NAK ends in fail", x_fail, 1);
    pkt(PID_IN, 1, 0, 3);
    gap(1, 1, 1, 0, 0, 0, 0, k);
    send_out(0, p);
    chk("R2", "STALL has priority", p, PID_STALL);
    chk("R4", "STALL ends in fail", x_fail, 1);
  endtask

  task automatic do_out(input logic [3:0] tok, input logic [3:0] dp, input bit nak,
                        input bit stl, input bit nyt, input logic [3:0] exp_hs,
                        input bit exp_good, input int ipd, input string req);
    int k; logic [3:0] p;
    pkt(tok, 1, 0, 3);
    chk(req, "OUT/SETUP indication", {a_out, a_setup}, (tok == PID_SETUP) ? 1 : 2);
    pkt(dp, 1, 0, 6);
    gap(0, nak, stl, nyt, 0, 0, 0, k);
    chk(req, "gap after data", k, ipd);
    send_out(0, p);
    chk(req, "handshake pid", p, exp_hs);
    chk(req, "outcome ok", x_ok, exp_good);
    chk(req, "outcome fail", x_fail, !exp_good);
    if (exp_good) out_exp_m = ~out_exp_m;
  endtask

  task automatic t_out();
    do_out(PID_OUT, dpid(out_exp_m), 0, 0, 0, PID_ACK, 1, FS_IPD, "R8");
    do_out(PID_OUT, dpid(~out_exp_m), 1, 0, 0, PID_ACK, 0, FS_IPD, "R8");
    do_out(PID_OUT, dpid(out_exp_m), 1, 0, 0, PID_NAK, 0, FS_IPD, "R8");
    do_out(PID_OUT, dpid(out_exp_m), 0, 0, 0, PID_ACK, 1, FS_IPD, "R8");
  endtask

  task automatic t_out_empty();
    bit sent = 1'b0;
    pkt(PID_OUT, 1, 0, 3);
    pkt(4'h0, 0, 0, 4);
    chk("R7", "empty data fails", x_fail, 1);
    repeat (25) begin @(negedge clk); if (tx_send) sent = 1'b1; end
    chk("R7", "no handshake after empty data", sent, 0);
  endtask

  task automatic t_setup();
    if (!out_exp_m) do_out(PID_OUT, PID_DATA0, 0, 0, 0, PID_ACK, 1, FS_IPD, "R8");
    out_exp_m = 1'b0;
    do_out(PID_SETUP, PID_DATA0, 1, 1, 0, PID_ACK, 1, FS_IPD, "R9");
  endtask

  task automatic t_nyet();
    hs_mode = 1'b1;
    do_out(PID_OUT, dpid(out_exp_m), 0, 0, 1, PID_NYET, 1, HS_IPD, "R10");
    hs_mode = 1'b0;
    do_out(PID_OUT, dpid(out_exp_m), 0, 0, 1, PID_ACK, 1, FS_IPD, "R10");
  endtask

  task automatic t_ping();
    int k; logic [3:0] p; bit sent = 1'b0;
    hs_mode = 1'b1;
    pkt(PID_PING, 1, 0, 3);
    chk("R11", "ping indication", {a_in, a_out, a_setup, a_ping}, 4'b0001);
    gap(0, 0, 0, 0, 0, 1, 1, k);
    chk("R11", "HS ping gap", k, HS_IPD);
    send_out(0, p);
    chk("R11", "ping ACK", p, PID_ACK);
    chk("R11", "ping ok", x_ok, 1);
    pkt(PID_PING, 1, 0, 3);
    gap(0, 1, 0, 0, 0, 0, 0, k);
    send_out(0, p);
    chk("R11", "ping NAK", p, PID_NAK);
    chk("R11", "ping NAK fails", x_fail, 1);
    hs_mode = 1'b0;
    pkt(PID_PING, 1, 0, 3);
    chk("R11", "FS ping ignored", a_ping, 0);
    repeat (30) begin @(negedge clk); if (tx_send) sent = 1'b1; end
    chk("R11", "FS ping no reply", sent, 0);
  endtask

  task automatic t_back2back();
    int k; logic [3:0] p;
    pkt(PID_IN, 1, 0, 3);
    gap(1, 0, 0, 0, 0, 0, 0, k);
    send_out(0, p);
    pkt(PID_ACK, 1, 0, 2);
    chk("R12", "first ok", x_ok, 1);
    in_tog_m = ~in_tog_m;
    pkt(PID_OUT, 1, 0, 0);
    chk("R12", "token right after outcome", a_out, 1);
    pkt(dpid(out_exp_m), 1, 0, 4);
    gap(0, 0, 0, 0, 0, 0, 0, k);
    send_out(0, p);
    chk("R12", "second transaction ok", x_ok, 1);
    out_exp_m = ~out_exp_m;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R1-none actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hs_mode = 1'b0; rx_act = 1'b0; rx_fin = 1'b0; rx_vld = 1'b0;
    rx_err = 1'b0; rx_pid = 4'h0; tx_done = 1'b0;
    a_send = 1'b0; a_nak = 1'b0; a_stall = 1'b0; a_nyet = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_ack();
    t_in_timeout();
    t_in_echo();
    t_in_empty();
    t_in_refuse();
    t_out();
    t_out_empty();
    t_setup();
    t_nyet();
    t_ping();
    t_back2back();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule